// File: doc/BRIEF.md
# Three-Channel Pulse-Width LED Gate

This block turns three 5-bit brightness codes into three on/off enables that gate constant-current LED sinks. A prescaler divides the system clock into count ticks; a free-running 5-bit frame counter advances on each tick, so one PWM frame lasts 32 ticks. Each channel compares its active code with the frame counter and drives its enable high for a share of the frame proportional to the code. With a 1 MHz clock and the default divide of 15, the frame rate comes out near 2.08 kHz.

Codes may be written at any time. Each channel holds a requested code and an active code; the active code is refreshed only as a frame wraps, so a write in mid-frame never cuts or stretches the pulse already under way. Two codes do not follow the plain ratio: the lowest keeps the channel dark and the highest keeps it lit for the whole frame. A shutdown input darkens all three enables at once, without waiting for a clock edge. The block only switches the sinks on and off; the current level itself is set elsewhere and is never touched here.

Top module: `tri_led_pwm`

## Requirements
- R1: An active code of 0 keeps that channel's enable low for the whole frame.
- R2: An active code of 31 (all ones) keeps that channel's enable high for every clock of the frame.
- R3: For an active code c with 1 <= c <= 30, the enable is high for c*CLK_DIV clocks out of each frame of 32*CLK_DIV clocks.
- R4: For codes 1 to 30 the high time is one contiguous pulse starting on the first clock of the frame (frame count 0), so the enable rises exactly once per frame.
- R5: A code written on duty_in in mid-frame has no effect on the frame in progress; it becomes active on the first clock of the next frame.
- R6: While shutdown is high all enables are low, in the same cycle shutdown rises, with no clock delay; when it falls the enables resume their pattern at once.
- R7: The three channels are independent: each channel's enable depends only on its own field of duty_in (channel k in bits [5k+4:5k]).
- R8: While reset is asserted all enables are low and the frame restarts at count 0 once reset is released.
- R9: The frame counter advances only on a prescaler tick, one tick every CLK_DIV clocks, and wraps from 31 to 0, giving a frame of 32*CLK_DIV clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shutdown | input | 1 | Forces all enables low while high |
| duty_in | input | NUM_CH*DUTY_W | Requested codes, channel k in bits [DUTY_W*k +: DUTY_W] |
| led_en | output | NUM_CH | Sink enable per channel, high = LED driven |

## Verification
Every one of the 32 codes is swept on channel 0 while channels 1 and 2 carry a mirrored and a scrambled code, so a mix-up between channels, an off-by-one in the comparison, or a wrong treatment of the two end codes shows up as a wrong high-time count or a wrong number of rising edges over one frame window. A mid-frame write from a short to a long code tells a shadowed update from an immediate one, since only the shadowed version gives the old width in the current frame and the new one in the next. Raising shutdown with all channels fully lit separates a combinational kill from a registered one, and the spacing between two rising edges pins down the frame length.

// File: rtl/tri_led_pwm_pkg.sv
package tri_led_pwm_pkg;

   // Gate level for one channel: zero code is dark, all-ones code is lit
   // for the full frame, anything else is lit while the count is below it.
   function automatic logic duty_gate(input logic [15:0] code,
                                      input logic [15:0] count,
                                      input logic [15:0] full_code);
      logic lvl;
      if (code == 16'd0)
         lvl = 1'b0;
      else if (code == full_code)
         lvl = 1'b1;
      else
         lvl = (count < code);
      return lvl;
   endfunction

endpackage

// File: rtl/tlp_prescaler.sv
module tlp_prescaler #(
   parameter int unsigned CLK_DIV = 15
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned PW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(CLK_DIV - 1);

   logic [PW-1:0] pre_q;

   assign tick = (pre_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_q <= '0;
      else if (tick)
         pre_q <= '0;
      else
         pre_q <= pre_q + 1'b1;
   end
endmodule

// File: rtl/tlp_frame_ctr.sv
module tlp_frame_ctr #(
   parameter int unsigned DUTY_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   output logic [DUTY_W-1:0] count,
   output logic              frame_end
);
   localparam logic [DUTY_W-1:0] TOP = {DUTY_W{1'b1}};

   assign frame_end = tick && (count == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (tick)
         count <= count + 1'b1;
   end
endmodule

// File: rtl/tlp_channel.sv
module tlp_channel
   import tri_led_pwm_pkg::*;
#(
   parameter int unsigned DUTY_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DUTY_W-1:0] duty_req,
   input  logic              frame_end,
   input  logic [DUTY_W-1:0] count,
   input  logic              shutdown,
   output logic [DUTY_W-1:0] duty_act,
   output logic              en
);
   localparam logic [15:0] FULL16 = 16'((1 << DUTY_W) - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         duty_act <= '0;
      else if (frame_end)
         duty_act <= duty_req;
   end

   always_comb begin
      en = !shutdown && duty_gate(16'(duty_act), 16'(count), FULL16);
   end
endmodule

// File: rtl/tri_led_pwm.sv
module tri_led_pwm #(
   parameter int unsigned NUM_CH  = 3,
   parameter int unsigned DUTY_W  = 5,
   parameter int unsigned CLK_DIV = 15
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     shutdown,
   input  logic [NUM_CH*DUTY_W-1:0] duty_in,
   output logic [NUM_CH-1:0]        led_en
);
   localparam int unsigned ACT_W = NUM_CH * DUTY_W;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("NUM_CH must be at least 1");
   end
   if (DUTY_W < 2 || DUTY_W > 15) begin : g_bad_w
      $error("DUTY_W must be within 2..15");
   end
   if (CLK_DIV < 1) begin : g_bad_div
      $error("CLK_DIV must be at least 1");
   end

   logic              tick;
   logic              frame_end;
   logic [DUTY_W-1:0] frame_cnt;
   logic [ACT_W-1:0]  act_flat;

   tlp_prescaler #(.CLK_DIV(CLK_DIV)) i_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   tlp_frame_ctr #(.DUTY_W(DUTY_W)) i_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .count     (frame_cnt),
      .frame_end (frame_end)
   );

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      tlp_channel #(.DUTY_W(DUTY_W)) i_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .duty_req  (duty_in[k*DUTY_W +: DUTY_W]),
         .frame_end (frame_end),
         .count     (frame_cnt),
         .shutdown  (shutdown),
         .duty_act  (act_flat[k*DUTY_W +: DUTY_W]),
         .en        (led_en[k])
      );
   end
endmodule

// File: rtl/tri_led_pwm_chk.sv
module tri_led_pwm_chk #(
   parameter int unsigned NUM_CH = 3,
   parameter int unsigned DUTY_W = 5
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     shutdown,
   input logic                     tick,
   input logic                     frame_end,
   input logic [DUTY_W-1:0]        cnt,
   input logic [NUM_CH*DUTY_W-1:0] act_flat,
   input logic [NUM_CH-1:0]        led_en
);
   // R6
   dark_on_shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown |-> (led_en == '0));

   // R9
   count_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != $past(cnt)) |-> $past(tick));

   // R9
   count_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(frame_end) |-> (cnt == '0));

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      // R5
      code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (act_flat[k*DUTY_W +: DUTY_W] != $past(act_flat[k*DUTY_W +: DUTY_W]))
            |-> $past(frame_end));

      // R4
      rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($rose(led_en[k]) && !$past(shutdown)) |-> (cnt == '0));
   end
endmodule

bind tri_led_pwm tri_led_pwm_chk #(.NUM_CH(NUM_CH), .DUTY_W(DUTY_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .shutdown  (shutdown),
   .tick      (tick),
   .frame_end (frame_end),
   .cnt       (frame_cnt),
   .act_flat  (act_flat),
   .led_en    (led_en)
);

// File: tb/test_tri_led_pwm.sv
module test_tri_led_pwm;
   localparam int NUM_CH = 3;
   localparam int DUTY_W = 5;
   localparam int DIV    = 3;
   localparam int FRAME  = 32 * DIV;

   logic                     clk = 1'b0;
   logic                     rst_n = 1'b0;
   logic                     shutdown = 1'b0;
   logic [NUM_CH*DUTY_W-1:0] duty_in = '0;
   logic [NUM_CH-1:0]        led_en;

   int n_run = 0;
   int n_fail = 0;
   int on_c [NUM_CH];
   int rise_c [NUM_CH];

   always #2.5 clk = ~clk;

   tri_led_pwm #(.NUM_CH(NUM_CH), .DUTY_W(DUTY_W), .CLK_DIV(DIV)) i_tri_led_pwm (
      .clk(clk), .rst_n(rst_n), .shutdown(shutdown),
      .duty_in(duty_in), .led_en(led_en)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int exp_on(input int code);
      if (code == 0) return 0;
      if (code == 31) return FRAME;
      return code * DIV;
   endfunction

   task automatic wait_clks(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Count high clocks and rising edges over one frame window (phase free).
   task automatic measure();
      logic [NUM_CH-1:0] prev;
      prev = led_en;
      for (int c = 0; c < NUM_CH; c++) begin
         on_c[c] = 0;
         rise_c[c] = 0;
      end
      for (int i = 0; i < FRAME; i++) begin
         @(negedge clk);
         for (int c = 0; c < NUM_CH; c++) begin
            if (led_en[c]) on_c[c]++;
            if (led_en[c] && !prev[c]) rise_c[c]++;
         end
         prev = led_en;
      end
   endtask

   task automatic sync_rise0();
      logic p;
      p = led_en[0];
      forever begin
         @(negedge clk);
         if (led_en[0] && !p) break;
         p = led_en[0];
      end
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int codes [NUM_CH];
      int cnt_a;
      int cnt_b;
      int gap;

      // R8: reset state
      duty_in = {5'd31, 5'd31, 5'd31};
      wait_clks(5);
      check(led_en == '0, "R8 reset dark", int'(led_en), 0);
      duty_in = '0;
      rst_n = 1'b1;
      wait_clks(2 * FRAME);
      check(led_en == '0, "R8 after reset zero code", int'(led_en), 0);

      // R1 R2 R3 R4 R7: full sweep of codes
      for (int code = 0; code < 32; code++) begin
         codes[0] = code;
         codes[1] = 31 - code;
         codes[2] = (code * 7 + 3) % 32;
         for (int c = 0; c < NUM_CH; c++) duty_in[c*DUTY_W +: DUTY_W] = 5'(codes[c]);
         wait_clks(2 * FRAME);
         measure();
         for (int c = 0; c < NUM_CH; c++) begin
            if (codes[c] == 0)
               check(on_c[c] == 0, "R1 code zero dark", on_c[c], 0);
            else if (codes[c] == 31)
               check(on_c[c] == FRAME, "R2 code full lit", on_c[c], FRAME);
            else if (c == 0)
               check(on_c[c] == exp_on(codes[c]), "R3 high time", on_c[c], exp_on(codes[c]));
            else
               check(on_c[c] == exp_on(codes[c]), "R7 independent channel", on_c[c], exp_on(codes[c]));
            check(rise_c[c] == ((codes[c] == 0 || codes[c] == 31) ? 0 : 1),
                  "R4 single pulse", rise_c[c],
                  (codes[c] == 0 || codes[c] == 31) ? 0 : 1);
         end
      end

      // R9: frame length from rise spacing
      duty_in = {5'd0, 5'd0, 5'd16};
      wait_clks(2 * FRAME);
      sync_rise0();
      gap = 0;
      begin
         logic p;
         p = led_en[0];
         forever begin
            @(negedge clk);
            gap++;
            if (led_en[0] && !p) break;
            p = led_en[0];
         end
      end
      check(gap == FRAME, "R9 frame length", gap, FRAME);

      // R5: mid-frame write waits for the frame boundary
      duty_in = {5'd0, 5'd0, 5'd5};
      wait_clks(2 * FRAME);
      sync_rise0();
      cnt_a = 1;
      for (int i = 1; i < FRAME; i++) begin
         if (i == 10) duty_in[0 +: DUTY_W] = 5'd20;
         @(negedge clk);
         if (led_en[0]) cnt_a++;
      end
      cnt_b = 0;
      for (int i = 0; i < FRAME; i++) begin
         @(negedge clk);
         if (led_en[0]) cnt_b++;
      end
      check(cnt_a == 5 * DIV, "R5 old code kept", cnt_a, 5 * DIV);
      check(cnt_b == 20 * DIV, "R5 new code next frame", cnt_b, 20 * DIV);

      // R6: shutdown is immediate and total
      duty_in = {5'd31, 5'd31, 5'd31};
      wait_clks(2 * FRAME);
      check(led_en == 3'b111, "R6 lit before shutdown", int'(led_en), 7);
      shutdown = 1'b1;
      #1;
      check(led_en == '0, "R6 immediate dark", int'(led_en), 0);
      measure();
      cnt_a = on_c[0] + on_c[1] + on_c[2];
      check(cnt_a == 0, "R6 dark whole frame", cnt_a, 0);
      shutdown = 1'b0;
      #1;
      check(led_en == 3'b111, "R6 resume", int'(led_en), 7);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule